// File: doc/BRIEF.md
# Trap Entry Sequencer

This block carries out the state changes a register-windowed RISC core makes when it enters a trap handler. The core presents a trap request with an 8-bit trap type, the current and next program counters, and its status fields: trap enable, supervisor mode, previous supervisor mode, current window pointer and the trap base register. One clock after the request is sampled, the block presents the updated status fields. It also presents the vector address as the new PC and the vector plus four as the new next PC. In the same cycle it gives a write strobe that stores the old PC and next PC into local registers 1 and 2 of the new window. When the trap type is an external interrupt, it also gives an acknowledge that carries the trap type.

A trap that arrives while trap enable is clear cannot be vectored. The block then goes into a halted error state that only reset clears. There is one exception: trap type 0x80 with the shutdown option input set. That case drives a shutdown request instead, which also holds until reset.

The controller has four states. ST_IDLE waits for a request. The transition "accept" moves from ST_IDLE to ST_VECTOR when a request arrives with trap enable set. ST_VECTOR lasts one cycle, in which done, the window write strobe and any acknowledge are high. The transition "return" then goes back to ST_IDLE. The transition "fault" moves from ST_IDLE to ST_HALT when a request arrives with trap enable clear, unless it is the shutdown case. The transition "power_off" moves from ST_IDLE to ST_OFF in the shutdown case. ST_HALT and ST_OFF have no exit except reset.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset the block is in ST_IDLE with done, wr_en, ack_valid, halted and shutdown_req low, and every status and PC output at zero.
- R2: A request sampled in ST_IDLE with en_in=1 makes done high for exactly one cycle, starting one cycle after the sampling edge, with en_out=0. The outputs then hold until the next trap.
- R3: On a vectored trap, cwp_out and wr_win equal cwp_in minus one modulo NWIN (0 wraps to NWIN-1).
- R4: During the done cycle, wr_en is high, wr_l1_data equals the sampled cur_pc and wr_l2_data equals the sampled cur_npc.
- R5: On a vectored trap, psup_out takes the sampled sup_in and sup_out is 1.
- R6: tbr_out keeps bits 31:12 of tbr_in, holds the trap type in bits 11:4 and has bits 3:0 at zero. pc_out equals tbr_out and npc_out equals tbr_out+4. This holds for all 256 trap types, including software traps (0x80 and above).
- R7: ack_valid is high during the done cycle exactly when trap type bits 7:4 equal 4'h1 (external interrupts 0x10-0x1F), and ack_type then carries the trap type.
- R8: A request with en_in=0 that is not the shutdown case enters ST_HALT: halted becomes 1 one cycle later, with no done, no wr_en, no acknowledge, and unchanged status and PC outputs.
- R9: A request with en_in=0, trap type 0x80 and shutdown_opt=1 raises shutdown_req and leaves halted low. With en_in=1 the same type vectors normally.
- R10: ST_HALT and ST_OFF ignore further requests and are left only through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 1 | Trap request, sampled in ST_IDLE |
| trap_type | input | 8 | Trap type number |
| cur_pc | input | 32 | Program counter at the trap |
| cur_npc | input | 32 | Next program counter at the trap |
| en_in | input | 1 | Trap enable status bit |
| sup_in | input | 1 | Supervisor status bit |
| psup_in | input | 1 | Previous supervisor status bit |
| cwp_in | input | $clog2(NWIN) | Current window pointer |
| tbr_in | input | 32 | Trap base register |
| shutdown_opt | input | 1 | Enables the shutdown case for type 0x80 |
| en_out | output | 1 | New trap enable bit |
| sup_out | output | 1 | New supervisor bit |
| psup_out | output | 1 | New previous supervisor bit |
| cwp_out | output | $clog2(NWIN) | New window pointer |
| tbr_out | output | 32 | New trap base register |
| pc_out | output | 32 | New program counter |
| npc_out | output | 32 | New next program counter |
| wr_en | output | 1 | Window write strobe |
| wr_win | output | $clog2(NWIN) | Window that receives the saved counters |
| wr_l1_data | output | 32 | Value for local register 1 (saved PC) |
| wr_l2_data | output | 32 | Value for local register 2 (saved next PC) |
| ack_valid | output | 1 | External interrupt acknowledge pulse |
| ack_type | output | 8 | Trap type carried with the acknowledge |
| done | output | 1 | Trap entry complete pulse |
| halted | output | 1 | Sticky error state |
| shutdown_req | output | 1 | Sticky shutdown request |

## Verification
A wrong controller state shows one cycle after the sampling edge. It appears as a missing or doubled done pulse, a halt where a vector was due, or a shutdown request for the wrong type. A fault in the datapath shows in that same done cycle as a wrong window number, a wrong saved counter, or a vector whose type field or base bits are wrong. The sweep covers every trap type against every window pointer, which exposes wrap and range-decode faults. Sticky states are tested by applying further requests after the fault and checking that the outputs do not change until reset.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_VECTOR,
        ST_HALT,
        ST_OFF
    } seq_state_t;

    localparam logic [7:0] SHUTDOWN_TT = 8'h80;
endpackage

// File: rtl/trap_vector_calc.sv
module trap_vector_calc #(
    parameter int NWIN     = 8,
    parameter int XLEN     = 32,
    parameter int TTW      = 8,
    parameter int IRQ_BASE = 1
) (
    input  logic [TTW-1:0]          trap_type,
    input  logic [$clog2(NWIN)-1:0] cwp_in,
    input  logic [XLEN-1:0]         tbr_in,
    output logic [$clog2(NWIN)-1:0] cwp_next,
    output logic [XLEN-1:0]         vec_addr,
    output logic [XLEN-1:0]         vec_next,
    output logic                    is_irq
);
    localparam int CWPW  = $clog2(NWIN);
    localparam int LOW_W = TTW + 4;
    localparam int GRPW  = TTW - 4;

    // Window decrement with wrap; handles non power of two counts
    always_comb begin
        if (cwp_in == '0)
            cwp_next = CWPW'(NWIN - 1);
        else
            cwp_next = cwp_in - 1'b1;
    end

    always_comb begin
        vec_addr = {tbr_in[XLEN-1:LOW_W], trap_type, 4'b0000};
        vec_next = vec_addr + XLEN'(4);
        is_irq   = (trap_type[TTW-1:4] == GRPW'(IRQ_BASE));
    end
endmodule

// File: rtl/trap_seq_fsm.sv
module trap_seq_fsm
    import trap_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trap_req,
    input  logic en_in,
    input  logic is_shutdown,
    output logic go_vec,
    output logic in_vector,
    output logic halted,
    output logic shutdown_req
);
    seq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (trap_req) begin
                    if (en_in)            state_d = ST_VECTOR;  // accept
                    else if (is_shutdown) state_d = ST_OFF;     // power_off
                    else                  state_d = ST_HALT;    // fault
                end
            end
            ST_VECTOR: state_d = ST_IDLE;                       // return
            ST_HALT:   state_d = ST_HALT;
            ST_OFF:    state_d = ST_OFF;
            default:   state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        go_vec       = 1'b0;
        in_vector    = 1'b0;
        halted       = 1'b0;
        shutdown_req = 1'b0;
        unique case (state_q)
            ST_IDLE:   go_vec       = trap_req & en_in;
            ST_VECTOR: in_vector    = 1'b1;
            ST_HALT:   halted       = 1'b1;
            ST_OFF:    shutdown_req = 1'b1;
            default:   halted       = 1'b1;
        endcase
    end

    p_done_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && trap_req && en_in) |=> in_vector);
    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_vector |=> !in_vector);
    p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted && !shutdown_req);
    p_off_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |=> shutdown_req && !halted);
    p_stopped_no_vector_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (halted || shutdown_req) |=> !in_vector);
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
    import trap_seq_pkg::*;
#(
    parameter int NWIN     = 8,
    parameter int IRQ_BASE = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    trap_req,
    input  logic [7:0]              trap_type,
    input  logic [31:0]             cur_pc,
    input  logic [31:0]             cur_npc,
    input  logic                    en_in,
    input  logic                    sup_in,
    input  logic                    psup_in,
    input  logic [$clog2(NWIN)-1:0] cwp_in,
    input  logic [31:0]             tbr_in,
    input  logic                    shutdown_opt,
    output logic                    en_out,
    output logic                    sup_out,
    output logic                    psup_out,
    output logic [$clog2(NWIN)-1:0] cwp_out,
    output logic [31:0]             tbr_out,
    output logic [31:0]             pc_out,
    output logic [31:0]             npc_out,
    output logic                    wr_en,
    output logic [$clog2(NWIN)-1:0] wr_win,
    output logic [31:0]             wr_l1_data,
    output logic [31:0]             wr_l2_data,
    output logic                    ack_valid,
    output logic [7:0]              ack_type,
    output logic                    done,
    output logic                    halted,
    output logic                    shutdown_req
);
    localparam int CWPW = $clog2(NWIN);
    localparam int XLEN = 32;
    localparam int TTW  = 8;

    logic [CWPW-1:0] cwp_next;
    logic [XLEN-1:0] vec_addr, vec_next;
    logic            is_irq, go_vec, in_vector, is_shutdown;

    // psup_in is replaced by the old supervisor bit on every trap
    logic unused_psup;
    assign unused_psup = psup_in;

    assign is_shutdown = shutdown_opt && (trap_type == SHUTDOWN_TT);

    trap_vector_calc #(
        .NWIN(NWIN), .XLEN(XLEN), .TTW(TTW), .IRQ_BASE(IRQ_BASE)
    ) u_calc (
        .trap_type(trap_type),
        .cwp_in   (cwp_in),
        .tbr_in   (tbr_in),
        .cwp_next (cwp_next),
        .vec_addr (vec_addr),
        .vec_next (vec_next),
        .is_irq   (is_irq)
    );

    trap_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .trap_req    (trap_req),
        .en_in       (en_in),
        .is_shutdown (is_shutdown),
        .go_vec      (go_vec),
        .in_vector   (in_vector),
        .halted      (halted),
        .shutdown_req(shutdown_req)
    );

    logic irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_out     <= 1'b0;
            sup_out    <= 1'b0;
            psup_out   <= 1'b0;
            cwp_out    <= '0;
            tbr_out    <= '0;
            pc_out     <= '0;
            npc_out    <= '0;
            wr_l1_data <= '0;
            wr_l2_data <= '0;
            ack_type   <= '0;
            irq_q      <= 1'b0;
        end else if (go_vec) begin
            en_out     <= 1'b0;
            sup_out    <= 1'b1;
            psup_out   <= sup_in;
            cwp_out    <= cwp_next;
            tbr_out    <= vec_addr;
            pc_out     <= vec_addr;
            npc_out    <= vec_next;
            wr_l1_data <= cur_pc;
            wr_l2_data <= cur_npc;
            ack_type   <= trap_type;
            irq_q      <= is_irq;
        end
    end

    assign done      = in_vector;
    assign wr_en     = in_vector;
    assign wr_win    = cwp_out;
    assign ack_valid = in_vector & irq_q;

    p_cwp_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cwp_out == (($past(cwp_in) == '0) ? CWPW'(NWIN - 1)
                                                    : CWPW'($past(cwp_in) - 1'b1)));
    p_saved_pc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_l1_data == $past(cur_pc)) && (wr_l2_data == $past(cur_npc)));
    p_mode_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> sup_out && (psup_out == $past(sup_in)) && !en_out);
    p_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (npc_out == pc_out + 32'd4) && (pc_out[3:0] == 4'h0)
                 && (pc_out[11:4] == $past(trap_type)));
    p_ack_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> done && (ack_type[7:4] == 4'(IRQ_BASE)));
    p_halt_holds_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc_out) && $stable(cwp_out));
endmodule

// File: tb/sim_trap_entry_seq.sv
module sim_trap_entry_seq;
    localparam int NWIN = 8;
    localparam int CWPW = $clog2(NWIN);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            trap_req = 1'b0;
    logic [7:0]      trap_type = '0;
    logic [31:0]     cur_pc = '0, cur_npc = '0, tbr_in = '0;
    logic            en_in = 1'b0, sup_in = 1'b0, psup_in = 1'b0, shutdown_opt = 1'b0;
    logic [CWPW-1:0] cwp_in = '0;
    logic            en_out, sup_out, psup_out, wr_en, ack_valid, done, halted, shutdown_req;
    logic [CWPW-1:0] cwp_out, wr_win;
    logic [31:0]     tbr_out, pc_out, npc_out, wr_l1_data, wr_l2_data;
    logic [7:0]      ack_type;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    trap_entry_seq #(.NWIN(NWIN)) u0 (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_type(trap_type),
        .cur_pc(cur_pc), .cur_npc(cur_npc), .en_in(en_in), .sup_in(sup_in),
        .psup_in(psup_in), .cwp_in(cwp_in), .tbr_in(tbr_in), .shutdown_opt(shutdown_opt),
        .en_out(en_out), .sup_out(sup_out), .psup_out(psup_out), .cwp_out(cwp_out),
        .tbr_out(tbr_out), .pc_out(pc_out), .npc_out(npc_out), .wr_en(wr_en),
        .wr_win(wr_win), .wr_l1_data(wr_l1_data), .wr_l2_data(wr_l2_data),
        .ack_valid(ack_valid), .ack_type(ack_type), .done(done), .halted(halted),
        .shutdown_req(shutdown_req)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        trap_req = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Drive a request for one sampling edge; returns at the negedge after it
    task automatic fire(input logic [7:0] tt, input logic [CWPW-1:0] cw, input logic en,
                        input logic sup, input logic opt,
                        input logic [31:0] pc, input logic [31:0] tbr);
        trap_type = tt; cwp_in = cw; en_in = en; sup_in = sup; psup_in = ~sup;
        shutdown_opt = opt; cur_pc = pc; cur_npc = pc + 32'd4; tbr_in = tbr;
        trap_req = 1'b1;
        @(negedge clk);
        trap_req = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 done", 64'(done), 0);
        chk("R1 wr_en", 64'(wr_en), 0);
        chk("R1 ack", 64'(ack_valid), 0);
        chk("R1 halted", 64'(halted), 0);
        chk("R1 shutdown", 64'(shutdown_req), 0);
        chk("R1 pc", 64'(pc_out), 0);
        chk("R1 cwp", 64'(cwp_out), 0);
        chk("R1 tbr", 64'(tbr_out), 0);

        // Sweep all trap types against all window pointers
        for (int c = 0; c < NWIN; c++) begin
            for (int t = 0; t < 256; t++) begin
                logic [31:0] pc, tbr, ev;
                logic [CWPW-1:0] ecw;
                logic sup;
                pc  = 32'h4000_0000 + 32'(t * 8 + c * 4096);
                tbr = {20'(t * 37 + c * 5 + 1), 12'hABC};
                sup = t[0] ^ c[0];
                ecw = (c == 0) ? CWPW'(NWIN - 1) : CWPW'(c - 1);
                ev  = {tbr[31:12], 8'(t), 4'h0};
                fire(8'(t), CWPW'(c), 1'b1, sup, 1'b1, pc, tbr);
                chk("R2 done", 64'(done), 1);
                chk("R2 en_out", 64'(en_out), 0);
                chk("R3 cwp_out", 64'(cwp_out), 64'(ecw));
                chk("R3 wr_win", 64'(wr_win), 64'(ecw));
                chk("R4 wr_en", 64'(wr_en), 1);
                chk("R4 l1", 64'(wr_l1_data), 64'(pc));
                chk("R4 l2", 64'(wr_l2_data), 64'(pc + 32'd4));
                chk("R5 sup/psup", 64'({sup_out, psup_out}), 64'({1'b1, sup}));
                chk("R6 tbr", 64'(tbr_out), 64'(ev));
                chk("R6 pc/npc", {pc_out, npc_out}, {ev, ev + 32'd4});
                chk("R7 ack", 64'(ack_valid), 64'(t >= 16 && t < 32));
                if (t >= 16 && t < 32) chk("R7 ack_type", 64'(ack_type), 64'(t));
                chk("R9 no shutdown when enabled", 64'({shutdown_req, halted}), 0);
                @(negedge clk);
                chk("R2 done low", 64'({done, wr_en, ack_valid}), 0);
                chk("R2 hold", 64'(pc_out), 64'(ev));
            end
        end

        // R8 disabled trap of type 0x80 without the option halts
        do_reset();
        fire(8'h12, 3'd5, 1'b1, 1'b0, 1'b0, 32'h1000, 32'h7777_7000);
        @(negedge clk);
        fire(8'h80, 3'd2, 1'b0, 1'b1, 1'b0, 32'h2000, 32'h1111_1000);
        chk("R8 halted", 64'(halted), 1);
        chk("R8 no done", 64'({done, wr_en, ack_valid, shutdown_req}), 0);
        chk("R8 pc held", 64'(pc_out), 64'h7777_7120);
        chk("R8 cwp held", 64'(cwp_out), 4);
        fire(8'h11, 3'd3, 1'b1, 1'b0, 1'b1, 32'h3000, 32'h2222_2000);
        chk("R10 halt ignores req", 64'({halted, done, wr_en, ack_valid}), 64'b1000);
        chk("R10 pc held", 64'(pc_out), 64'h7777_7120);
        do_reset();
        chk("R10 reset leaves halt", 64'(halted), 0);

        // R8 disabled non-0x80 with option set still halts
        fire(8'h05, 3'd1, 1'b0, 1'b0, 1'b1, 32'h0, 32'h0);
        chk("R8 halt other type", 64'({halted, shutdown_req}), 64'b10);

        // R9 shutdown case
        do_reset();
        fire(8'h80, 3'd0, 1'b0, 1'b1, 1'b1, 32'h5000, 32'h3333_3000);
        chk("R9 shutdown", 64'({shutdown_req, halted, done, wr_en}), 64'b1000);
        chk("R9 pc held", 64'(pc_out), 0);
        fire(8'h20, 3'd6, 1'b1, 1'b0, 1'b0, 32'h6000, 32'h4444_4000);
        repeat (3) @(negedge clk);
        chk("R10 off ignores req", 64'({shutdown_req, halted, done}), 64'b100);
        do_reset();
        chk("R10 reset leaves off", 64'(shutdown_req), 0);

        // R9 type 0x80 with option but enabled vectors normally
        fire(8'h80, 3'd0, 1'b1, 1'b0, 1'b1, 32'h5000, 32'h3333_3000);
        chk("R9 enabled 0x80 vectors", 64'({done, shutdown_req}), 64'b10);
        chk("R9 enabled 0x80 pc", 64'(pc_out), 64'h3333_3800);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule